// File: doc/BRIEF.md
# Table-Driven Rotation State Machine

This block follows rotation and direction by walking a state table held in an external synchronous memory. When an external timing sequencer finishes a measurement, it raises its stop signal. On that rising edge the block forms a table address and reads one 8-bit entry. The address joins the latched previous-state bits with the current sensor bits. No host access is needed for the read. The entry decides two things: the state bits used for the next lookup, and the strobes that step a rotation counter up or down or raise an interrupt.

A layout select sets how the address is split. In the wide layout, the two low address bits come from the sensors and the five upper bits are the state. In the narrow layout, three sensor bits and four state bits are used. Rising stop edges are ignored in three cases: during an inserted test cycle, while the block is disabled, and while an earlier read is still in flight.

Top module: `rotseq_core`

## Requirements
- R1: While reset is asserted, `rd_en_o`, `state_o`, `flags_o`, `cnt_inc_o`, `cnt_dec_o` and `irq_o` are all zero.
- R2: A qualifying edge sampled at clock edge E makes `rd_en_o` high for exactly the one cycle after E. A qualifying edge means `en_i`=1, `stop_i`=1, `stop_i` was 0 at the previous edge, `test_i`=0, and no read is in flight.
- R3: A rising stop edge with `test_i`=1 starts no read.
- R4: With `mode_i`=0 (wide), `rd_addr_o` = {state_o[4:0], sens_i[1:0]}, taken at edge E.
- R5: With `mode_i`=1 (narrow), `rd_addr_o` = {state_o[3:0], sens_i[2:0]}, taken at edge E.
- R6: `rd_data_i` is sampled at edge E+2, one cycle after the read cycle. The data is loaded there into `state_o` and into `flags_o` = entry bits [7:5]. `state_o` takes entry bits [4:0] in the wide layout, or entry bits [3:0] with bit 4 forced to 0 in the narrow layout. The layout is the one chosen at E. Between loads, `state_o` holds.
- R7: For the cycle after E+2, `cnt_inc_o` = Q6 & ~Q7 and `cnt_dec_o` = Q6 & Q7, where Qn is bit n of the entry. The two are never high together.
- R8: For the cycle after E+2, `irq_o` = Q7 & `irq_en_i` (sampled at E+2).
- R9: While `en_i`=0, stop edges are ignored, any read in flight is abandoned, and the state, flags and strobes clear to zero at the next edge.
- R10: A stop edge that arrives while a read is in flight (edges E+1 and E+2) is dropped and is not retried.
- R11: A stop level held high over many cycles starts only one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| mode_i | input | 1 | Address layout: 0 wide, 1 narrow |
| stop_i | input | 1 | Sequencer stop signal |
| test_i | input | 1 | High during an inserted test cycle |
| sens_i | input | 3 | Current sensor bits |
| irq_en_i | input | 1 | Enable for the Q7 interrupt strobe |
| rd_en_o | output | 1 | Table read request |
| rd_addr_o | output | 7 | Table read address |
| rd_data_i | input | 8 | Table entry, valid one cycle after the request |
| state_o | output | 5 | State latch |
| flags_o | output | 3 | Output latch, entry bits 7:5 |
| cnt_inc_o | output | 1 | Count-up strobe |
| cnt_dec_o | output | 1 | Count-down strobe |
| irq_o | output | 1 | Interrupt strobe |

## Verification
Take E as the clock edge where a qualifying stop edge is seen. The read request and address appear right after E. The memory answers after E+1. The state latch, flags and strobes change right after E+2, and the strobes drop again after E+3. The bench's behavioural model advances at the same edges and is compared with every output 5 ns after each rising edge. A timing slip of one cycle in any stage therefore shows up as a mismatch. Directed counts of read requests cover the dropped-trigger cases: test cycle, disabled block, in-flight read and held stop level.

// File: rtl/rotseq_pkg.sv
`timescale 1ns/1ps
package rotseq_pkg;
   typedef enum logic {
      LAYOUT_WIDE   = 1'b0,
      LAYOUT_NARROW = 1'b1
   } layout_e;

   typedef enum logic [1:0] {
      STG_IDLE = 2'd0,
      STG_READ = 2'd1,
      STG_WAIT = 2'd2
   } stage_e;
endpackage

// File: rtl/rotseq_trig.sv
`timescale 1ns/1ps
module rotseq_trig (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic stop_i,
   input  logic test_i,
   input  logic busy_i,
   output logic stop_prev_o,
   output logic fire_o
);
   logic stop_q;

   // previous stop level is tracked even while disabled, so enabling
   // with stop already high does not look like a fresh edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= stop_i;
   end

   assign stop_prev_o = stop_q;
   assign fire_o      = en_i && stop_i && !stop_q && !test_i && !busy_i;
endmodule

// File: rtl/rotseq_fetch.sv
`timescale 1ns/1ps
module rotseq_fetch
   import rotseq_pkg::*;
#(
   parameter int ST_W = 5,
   parameter int SW   = 2,
   localparam int ADDR_W = ST_W + SW,
   localparam int SENS_W = SW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              fire_i,
   input  layout_e           mode_i,
   input  logic [ST_W-1:0]   state_i,
   input  logic [SENS_W-1:0] sens_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              busy_o,
   output logic              cap_o,
   output layout_e           cap_mode_o
);
   stage_e            stage_q;
   logic [ADDR_W-1:0] wide_addr;
   logic [ADDR_W-1:0] narrow_addr;
   logic [ADDR_W-1:0] addr_q;
   layout_e           mode_q;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_abit
      if (i < SW) begin : g_sens
         assign wide_addr[i]   = sens_i[i];
         assign narrow_addr[i] = sens_i[i];
      end else if (i == SW) begin : g_mid
         assign wide_addr[i]   = state_i[0];
         assign narrow_addr[i] = sens_i[SW];
      end else begin : g_st
         assign wide_addr[i]   = state_i[i-SW];
         assign narrow_addr[i] = state_i[i-SW-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= STG_IDLE;
         addr_q  <= '0;
         mode_q  <= LAYOUT_WIDE;
      end else if (!en_i) begin
         stage_q <= STG_IDLE;
      end else begin
         unique case (stage_q)
            STG_IDLE: if (fire_i) begin
               stage_q <= STG_READ;
               addr_q  <= (mode_i == LAYOUT_NARROW) ? narrow_addr : wide_addr;
               mode_q  <= mode_i;
            end
            STG_READ: stage_q <= STG_WAIT;
            default:  stage_q <= STG_IDLE;
         endcase
      end
   end

   assign rd_en_o    = (stage_q == STG_READ);
   assign rd_addr_o  = addr_q;
   assign busy_o     = (stage_q != STG_IDLE);
   assign cap_o      = (stage_q == STG_WAIT);
   assign cap_mode_o = mode_q;

   AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_o |=> !rd_en_o); // R2
   AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rd_en_o, 2) |-> !rd_en_o); // R10
endmodule

// File: rtl/rotseq_latch.sv
`timescale 1ns/1ps
module rotseq_latch
   import rotseq_pkg::*;
#(
   parameter int ENTRY_W = 8,
   parameter int ST_W    = 5,
   parameter int CNT_BIT = 6,
   parameter int DIR_BIT = 7,
   parameter int IRQ_BIT = 7,
   parameter int FLAG_LO = 5,
   localparam int FLAG_W = ENTRY_W - FLAG_LO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               cap_i,
   input  layout_e            cap_mode_i,
   input  logic [ENTRY_W-1:0] rd_data_i,
   input  logic               irq_en_i,
   output logic [ST_W-1:0]    state_o,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               cnt_inc_o,
   output logic               cnt_dec_o,
   output logic               irq_o
);
   logic [ST_W-1:0] st_nxt;

   for (genvar i = 0; i < ST_W; i++) begin : g_sbit
      if (i == ST_W - 1) begin : g_top
         assign st_nxt[i] = (cap_mode_i == LAYOUT_NARROW) ? 1'b0 : rd_data_i[i];
      end else begin : g_low
         assign st_nxt[i] = rd_data_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o   <= '0;
         flags_o   <= '0;
         cnt_inc_o <= 1'b0;
         cnt_dec_o <= 1'b0;
         irq_o     <= 1'b0;
      end else if (!en_i) begin
         state_o   <= '0;
         flags_o   <= '0;
         cnt_inc_o <= 1'b0;
         cnt_dec_o <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         cnt_inc_o <= cap_i && rd_data_i[CNT_BIT] && !rd_data_i[DIR_BIT];
         cnt_dec_o <= cap_i && rd_data_i[CNT_BIT] &&  rd_data_i[DIR_BIT];
         irq_o     <= cap_i && irq_en_i && rd_data_i[IRQ_BIT];
         if (cap_i) begin
            state_o <= st_nxt;
            flags_o <= rd_data_i[ENTRY_W-1:FLAG_LO];
         end
      end
   end

   AST_INC_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cnt_inc_o && cnt_dec_o)); // R7
   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !cap_i) |=> $stable(state_o)); // R6
   AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && cap_i && cap_mode_i == LAYOUT_NARROW) |=> !state_o[ST_W-1]); // R6
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(irq_en_i)); // R8
   AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (state_o == '0 && flags_o == '0 && !irq_o && !cnt_inc_o && !cnt_dec_o)); // R9
endmodule

// File: rtl/rotseq_core.sv
`timescale 1ns/1ps
module rotseq_core
   import rotseq_pkg::*;
#(
   parameter int ST_W    = 5,
   parameter int SW      = 2,
   parameter int ENTRY_W = 8,
   parameter int CNT_BIT = 6,
   parameter int DIR_BIT = 7,
   parameter int IRQ_BIT = 7,
   parameter int FLAG_LO = 5,
   localparam int ADDR_W = ST_W + SW,
   localparam int SENS_W = SW + 1,
   localparam int FLAG_W = ENTRY_W - FLAG_LO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               mode_i,
   input  logic               stop_i,
   input  logic               test_i,
   input  logic [SENS_W-1:0]  sens_i,
   input  logic               irq_en_i,
   output logic               rd_en_o,
   output logic [ADDR_W-1:0]  rd_addr_o,
   input  logic [ENTRY_W-1:0] rd_data_i,
   output logic [ST_W-1:0]    state_o,
   output logic [FLAG_W-1:0]  flags_o,
   output logic               cnt_inc_o,
   output logic               cnt_dec_o,
   output logic               irq_o
);
   if (ST_W < 2 || SW < 1) begin : g_bad_split
      $error("rotseq_core: state needs >=2 bits and sensors >=1 bit");
   end
   if (ST_W > ENTRY_W || FLAG_LO >= ENTRY_W || FLAG_LO < 0) begin : g_bad_fields
      $error("rotseq_core: state or flag field outside the entry");
   end
   if (CNT_BIT >= ENTRY_W || DIR_BIT >= ENTRY_W || IRQ_BIT >= ENTRY_W || CNT_BIT == DIR_BIT) begin : g_bad_ctrl
      $error("rotseq_core: control bit positions invalid");
   end

   logic    fire;
   logic    busy;
   logic    stop_prev;
   logic    cap;
   layout_e cap_mode;
   layout_e mode_sel;

   assign mode_sel = layout_e'(mode_i);

   rotseq_trig u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (en_i),
      .stop_i      (stop_i),
      .test_i      (test_i),
      .busy_i      (busy),
      .stop_prev_o (stop_prev),
      .fire_o      (fire)
   );

   rotseq_fetch #(.ST_W(ST_W), .SW(SW)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .fire_i     (fire),
      .mode_i     (mode_sel),
      .state_i    (state_o),
      .sens_i     (sens_i),
      .rd_en_o    (rd_en_o),
      .rd_addr_o  (rd_addr_o),
      .busy_o     (busy),
      .cap_o      (cap),
      .cap_mode_o (cap_mode)
   );

   rotseq_latch #(
      .ENTRY_W (ENTRY_W), .ST_W (ST_W), .CNT_BIT (CNT_BIT),
      .DIR_BIT (DIR_BIT), .IRQ_BIT (IRQ_BIT), .FLAG_LO (FLAG_LO)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_i),
      .cap_i      (cap),
      .cap_mode_i (cap_mode),
      .rd_data_i  (rd_data_i),
      .irq_en_i   (irq_en_i),
      .state_o    (state_o),
      .flags_o    (flags_o),
      .cnt_inc_o  (cnt_inc_o),
      .cnt_dec_o  (cnt_dec_o),
      .irq_o      (irq_o)
   );

   AST_TEST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !stop_prev && test_i) |=> !rd_en_o); // R3
   AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !rd_en_o); // R9
endmodule

// File: tb/rotseq_core_test.sv
`timescale 1ns/1ps
module rotseq_core_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, mode = 1'b0, stop = 1'b0, test = 1'b0, irq_en = 1'b0;
   logic [2:0] sens = '0;
   logic       rd_en;
   logic [6:0] rd_addr;
   logic [7:0] rd_data = '0;
   logic [4:0] state;
   logic [2:0] flags;
   logic       inc, dec, irq;

   int    n_cmp = 0, n_bad = 0, n_fetch = 0;
   bit    run_cmp = 1'b0, done = 1'b0;
   string phase = "reset";

   // behavioural reference
   int         m_stage = 0;
   logic [6:0] m_addr = '0;
   logic       m_mode = 1'b0;
   logic [4:0] m_state = '0;
   logic [2:0] m_flags = '0;
   logic       m_inc = 1'b0, m_dec = 1'b0, m_irq = 1'b0, m_prev = 1'b0;
   logic [7:0] m_rdata = '0;

   always #10 clk = ~clk;

   rotseq_core uut (
      .clk (clk), .rst_n (rst_n), .en_i (en), .mode_i (mode), .stop_i (stop),
      .test_i (test), .sens_i (sens), .irq_en_i (irq_en), .rd_en_o (rd_en),
      .rd_addr_o (rd_addr), .rd_data_i (rd_data), .state_o (state),
      .flags_o (flags), .cnt_inc_o (inc), .cnt_dec_o (dec), .irq_o (irq)
   );

   function automatic logic [7:0] tbl(input logic [6:0] a);
      return 8'((int'(a) * 29 + 7) ^ (int'(a) >> 3));
   endfunction

   always @(posedge clk) if (rd_en) rd_data <= tbl(rd_addr);

   task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] actual=%0h expected=%0h", tag, phase, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      int         old;
      logic       edg;
      logic [7:0] d;
      if (!rst_n) begin
         m_stage = 0; m_state = '0; m_flags = '0; m_prev = 1'b0;
         m_inc = 1'b0; m_dec = 1'b0; m_irq = 1'b0;
      end else begin
         old = m_stage;
         edg = stop && !m_prev;
         m_prev = stop;
         m_inc = 1'b0; m_dec = 1'b0; m_irq = 1'b0;
         if (!en) begin
            m_stage = 0; m_state = '0; m_flags = '0;
         end else begin
            if (old == 2) begin
               d = m_rdata;
               m_state = m_mode ? {1'b0, d[3:0]} : d[4:0];
               m_flags = d[7:5];
               m_inc = d[6] && !d[7];
               m_dec = d[6] && d[7];
               m_irq = d[7] && irq_en;
            end
            if (old == 0 && edg && !test) begin
               m_stage = 1;
               m_mode  = mode;
               m_addr  = mode ? {m_state[3:0], sens[2:0]} : {m_state[4:0], sens[1:0]};
            end else if (old == 1) m_stage = 2;
            else if (old == 2) m_stage = 0;
         end
         if (old == 1) m_rdata = tbl(m_addr);
      end
      #5;
      if (run_cmp) begin
         if (rd_en === 1'b1) n_fetch++;
         cmp("R2 rd_en", {7'd0, rd_en}, {7'd0, m_stage == 1});
         if (m_stage == 1) cmp(m_mode ? "R5 narrow addr" : "R4 wide addr", {1'b0, rd_addr}, {1'b0, m_addr});
         cmp("R6 state", {3'd0, state}, {3'd0, m_state});
         cmp("R6 flags", {5'd0, flags}, {5'd0, m_flags});
         cmp("R7 inc/dec", {6'd0, inc, dec}, {6'd0, m_inc, m_dec});
         cmp("R8 irq", {7'd0, irq}, {7'd0, m_irq});
      end
   end

   task automatic pulse(input logic t);
      stop = 1'b1; test = t;
      @(negedge clk);
      stop = 1'b0; test = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int f0;
      repeat (3) @(negedge clk);
      cmp("R1 rd_en in reset", {7'd0, rd_en}, 8'd0);
      cmp("R1 state in reset", {3'd0, state}, 8'd0);
      cmp("R1 flags in reset", {5'd0, flags}, 8'd0);
      cmp("R1 strobes in reset", {5'd0, inc, dec, irq}, 8'd0);
      rst_n = 1'b1; en = 1'b1; run_cmp = 1'b1;
      @(negedge clk);

      phase = "wide";
      mode = 1'b0;
      for (int k = 0; k < 14; k++) begin
         sens = 3'(k * 5); irq_en = k[0];
         pulse(1'b0);
      end
      f0 = n_fetch; pulse(1'b0);
      cmp("R2 one read per edge", 8'(n_fetch - f0), 8'd1);

      phase = "narrow";
      mode = 1'b1;
      for (int k = 0; k < 14; k++) begin
         sens = 3'(k * 3); irq_en = ~k[1];
         pulse(1'b0);
      end

      phase = "test cycle";
      f0 = n_fetch;
      for (int k = 0; k < 3; k++) pulse(1'b1);
      cmp("R3 test edges start nothing", 8'(n_fetch - f0), 8'd0);

      phase = "edge in flight";
      f0 = n_fetch;
      stop = 1'b1; @(negedge clk); stop = 1'b0; @(negedge clk);
      stop = 1'b1; @(negedge clk); stop = 1'b0;
      repeat (5) @(negedge clk);
      cmp("R10 in-flight edge dropped", 8'(n_fetch - f0), 8'd1);

      phase = "held stop";
      f0 = n_fetch;
      stop = 1'b1; repeat (10) @(negedge clk);
      stop = 1'b0; repeat (4) @(negedge clk);
      cmp("R11 held level reads once", 8'(n_fetch - f0), 8'd1);

      phase = "disabled";
      f0 = n_fetch;
      en = 1'b0;
      pulse(1'b0); pulse(1'b0);
      cmp("R9 no read while disabled", 8'(n_fetch - f0), 8'd0);
      cmp("R9 state cleared", {3'd0, state}, 8'd0);
      en = 1'b1; repeat (2) @(negedge clk);

      phase = "disable mid-read";
      mode = 1'b0;
      for (int k = 0; k < 4; k++) begin sens = 3'(k + 1); pulse(1'b0); end
      stop = 1'b1; @(negedge clk); stop = 1'b0; en = 1'b0;
      repeat (3) @(negedge clk);
      cmp("R9 abandoned read leaves state clear", {3'd0, state}, 8'd0);
      en = 1'b1; repeat (2) @(negedge clk);

      phase = "wide irq";
      irq_en = 1'b1;
      for (int k = 0; k < 10; k++) begin sens = 3'(k * 7); pulse(1'b0); end
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule